// File: doc/BRIEF.md
# Compressed ISA Register ALU

This block is the execute stage for the sixteen register-to-register arithmetic and logic operations of a 16-bit compressed instruction set. Each request carries a 4-bit opcode, the destination operand (the current value of Rd), the source operand (the value of Rs) and the current condition flags. The response gives the 32-bit result, a write-enable that says whether Rd is to be updated, and the next condition flags. Register file access and instruction fetch belong to the surrounding pipeline.

The datapath is combinational, followed by a single output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The response appears on the output side on the next edge. A response stays on the outputs without change for as long as `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Because of this, a stalled consumer holds back the producer with no loss and no duplication.

Flags travel as a 4-bit vector: bit 3 N, bit 2 Z, bit 1 C, bit 0 V. Shifts use only the low byte of Rs as the amount. Add-type operations report carry as the adder carry-out. Subtract-type operations report carry as "no borrow".

Top module: `cisa_reg_alu`

## Requirements
- R1: A request is taken on an edge where `in_valid` and `in_ready` are both high, and its response is on the outputs after that edge with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the response fields stay unchanged. Reset (`rst_n` low) clears `out_valid`.
- R2: Opcode 0 gives Rd AND Rs, 1 gives Rd XOR Rs, 12 gives Rd OR Rs, 14 gives Rd AND NOT Rs, and 15 gives NOT Rs.
- R3: Opcodes 8 (test, Rd AND Rs), 10 (compare, Rd minus Rs) and 11 (compare-negative, Rd plus Rs) drive `out_wr_en` low and still update the flags. Every other opcode drives `out_wr_en` high.
- R4: For every opcode, N (flag bit 3) equals result bit 31, and Z (flag bit 2) is set exactly when the 32-bit result is zero.
- R5: Opcodes 0, 1, 8, 12, 13, 14 and 15 pass C (bit 1) and V (bit 0) through from the input flags unchanged.
- R6: Opcode 13 gives the low 32 bits of Rd times Rs.
- R7: Opcode 5 computes Rd + Rs + C_in, and opcode 11 computes Rd + Rs. For both, C is the carry out of bit 31 and V is the signed overflow.
- R8: Opcode 6 computes Rd - Rs - (1 - C_in), opcode 10 computes Rd - Rs, and opcode 9 computes 0 - Rs. For these, C is 1 when no borrow occurs and V is the signed overflow.
- R9: For shift opcodes 2 (left), 3 (logical right), 4 (arithmetic right) and 7 (rotate right) with a shift amount of zero, the result is Rd and C is unchanged. All shift opcodes leave V unchanged.
- R10: Left shift by 1 to 31 sets C to the last bit shifted out. By exactly 32 it gives zero with C = Rd bit 0. Logical right shift by 1 to 31 sets C to the last bit shifted out. By exactly 32 it gives zero with C = Rd bit 31. Above 32, both give zero with C = 0.
- R11: Arithmetic right shift by 1 to 31 fills with the sign bit and sets C to the last bit shifted out. By 32 or more, the result is 32 copies of Rd bit 31, and C equals Rd bit 31.
- R12: Rotate right by a nonzero amount rotates by the amount modulo 32 and sets C to result bit 31. A nonzero multiple of 32 leaves Rd as it is and sets C to Rd bit 31.
- R13: Only bits 7:0 of Rs set the shift amount, so bits 31:8 of Rs have no effect on any shift opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_rd | input | W | Destination operand value |
| in_rs | input | W | Source operand value |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_result | output | W | Operation result |
| out_wr_en | output | 1 | Rd is to be written with `out_result` |
| out_flags | output | 4 | Next flags {N,Z,C,V} |

## Verification
The assertions assume the producer leaves `in_op`, `in_rd`, `in_rs` and `in_flags` settled at the edge where a request is taken. They also assume that `rst_n` is held low for at least one edge before any request. The stimulus changes every input only on the falling clock edge and starts requests only after reset is released. Random shift amounts are drawn mostly from a band around 0, 1, 31, 32, 33 and 255 so that every range boundary of the shifter is hit many times. Flags and operands are fully random, so the carry-in and overflow corners of the adder come up on their own.

// File: rtl/cisa_alu_pkg.sv
package cisa_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_XOR = 4'd1,
    OP_LSL = 4'd2,
    OP_LSR = 4'd3,
    OP_ASR = 4'd4,
    OP_ADC = 4'd5,
    OP_SBC = 4'd6,
    OP_ROR = 4'd7,
    OP_TST = 4'd8,
    OP_NEG = 4'd9,
    OP_CMP = 4'd10,
    OP_CMN = 4'd11,
    OP_ORR = 4'd12,
    OP_MUL = 4'd13,
    OP_BIC = 4'd14,
    OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_LRIGHT = 2'd1,
    SH_ARIGHT = 2'd2,
    SH_ROTATE = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/cisa_shift_unit.sv
module cisa_shift_unit
  import cisa_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     a,
  input  logic [AMT_W-1:0] amt,
  input  shift_kind_e      kind,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  // W is taken as a power of two; the rotate uses modulo-W wrap of the amount.
  localparam int SH_W = $clog2(W);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  logic [SH_W-1:0] sh;
  logic [SH_W-1:0] sh_neg;
  logic            amt_zero;
  logic            amt_eq_w;
  logic            amt_gt_w;
  logic [W:0]      left_ext;
  logic [W:0]      right_ext;
  logic signed [W:0] arith_ext;
  logic [W-1:0]    rot_val;

  assign sh       = amt[SH_W-1:0];
  assign sh_neg   = SH_W'(0) - sh;
  assign amt_zero = (amt == '0);
  assign amt_eq_w = (amt == W_AMT);
  assign amt_gt_w = (amt > W_AMT);

  // Extended shifts keep the last bit moved out next to the kept bits.
  assign left_ext  = {1'b0, a} << sh;
  assign right_ext = {a, 1'b0} >> sh;
  assign arith_ext = $signed({a, 1'b0}) >>> sh;
  assign rot_val   = (a >> sh) | (a << sh_neg);

  always_comb begin
    res  = a;
    cout = cin;
    if (!amt_zero) begin
      unique case (kind)
        SH_LEFT: begin
          if (amt_gt_w) begin
            res  = '0;
            cout = 1'b0;
          end else if (amt_eq_w) begin
            res  = '0;
            cout = a[0];
          end else begin
            res  = left_ext[W-1:0];
            cout = left_ext[W];
          end
        end
        SH_LRIGHT: begin
          if (amt_gt_w) begin
            res  = '0;
            cout = 1'b0;
          end else if (amt_eq_w) begin
            res  = '0;
            cout = a[W-1];
          end else begin
            res  = right_ext[W:1];
            cout = right_ext[0];
          end
        end
        SH_ARIGHT: begin
          if (amt_gt_w || amt_eq_w) begin
            res  = {W{a[W-1]}};
            cout = a[W-1];
          end else begin
            res  = arith_ext[W:1];
            cout = arith_ext[0];
          end
        end
        default: begin
          if (sh == '0) begin
            res  = a;
            cout = a[W-1];
          end else begin
            res  = rot_val;
            cout = rot_val[W-1];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cisa_addsub_unit.sv
module cisa_addsub_unit
  import cisa_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] rd,
  input  logic [W-1:0] rs,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         carry_in;
  logic [W:0]   total;

  // One adder serves all five add/subtract operations; subtraction is
  // a + ~b + carry, so carry out is the no-borrow indication.
  always_comb begin
    opa      = rd;
    opb      = rs;
    carry_in = 1'b0;
    unique case (op)
      OP_ADC: begin
        opb      = rs;
        carry_in = cin;
      end
      OP_SBC: begin
        opb      = ~rs;
        carry_in = cin;
      end
      OP_CMP: begin
        opb      = ~rs;
        carry_in = 1'b1;
      end
      OP_NEG: begin
        opa      = '0;
        opb      = ~rs;
        carry_in = 1'b1;
      end
      default: begin
        opb      = rs;
        carry_in = 1'b0;
      end
    endcase
  end

  assign total = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, carry_in};
  assign sum   = total[W-1:0];
  assign cout  = total[W];
  assign ovf   = (opa[W-1] == opb[W-1]) && (total[W-1] != opa[W-1]);

endmodule

// File: rtl/cisa_logic_unit.sv
module cisa_logic_unit
  import cisa_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] rd,
  input  logic [W-1:0] rs,
  output logic [W-1:0] res
);
  logic [W-1:0] prod;

  assign prod = rd * rs;

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = rd & rs;
      OP_XOR:         res = rd ^ rs;
      OP_ORR:         res = rd | rs;
      OP_MUL:         res = prod;
      OP_BIC:         res = rd & ~rs;
      OP_MVN:         res = ~rs;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/cisa_reg_alu.sv
module cisa_reg_alu
  import cisa_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_rd,
  input  logic [W-1:0] in_rs,
  input  logic [3:0]   in_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wr_en,
  output logic [3:0]   out_flags
);
  alu_op_e     op;
  alu_flags_t  cur_fl;
  alu_flags_t  nxt_fl;
  shift_kind_e sh_kind;
  logic        is_shift;
  logic        is_arith;
  logic        wr_en;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] as_res;
  logic         as_c;
  logic         as_v;
  logic [W-1:0] lg_res;
  logic [W-1:0] result;
  logic         take;

  assign op     = alu_op_e'(in_op);
  assign cur_fl = alu_flags_t'(in_flags);

  // Operation class decode.
  always_comb begin
    is_shift = 1'b0;
    is_arith = 1'b0;
    wr_en    = 1'b1;
    sh_kind  = SH_LEFT;
    unique case (op)
      OP_LSL: begin is_shift = 1'b1; sh_kind = SH_LEFT;   end
      OP_LSR: begin is_shift = 1'b1; sh_kind = SH_LRIGHT; end
      OP_ASR: begin is_shift = 1'b1; sh_kind = SH_ARIGHT; end
      OP_ROR: begin is_shift = 1'b1; sh_kind = SH_ROTATE; end
      OP_ADC, OP_SBC, OP_NEG: is_arith = 1'b1;
      OP_CMP, OP_CMN: begin
        is_arith = 1'b1;
        wr_en    = 1'b0;
      end
      OP_TST: wr_en = 1'b0;
      default: ;
    endcase
  end

  cisa_shift_unit #(.W(W), .AMT_W(AMT_W)) u_shift (
    .a    (in_rd),
    .amt  (in_rs[AMT_W-1:0]),
    .kind (sh_kind),
    .cin  (cur_fl.c),
    .res  (sh_res),
    .cout (sh_c)
  );

  cisa_addsub_unit #(.W(W)) u_addsub (
    .op   (op),
    .rd   (in_rd),
    .rs   (in_rs),
    .cin  (cur_fl.c),
    .sum  (as_res),
    .cout (as_c),
    .ovf  (as_v)
  );

  cisa_logic_unit #(.W(W)) u_logic (
    .op  (op),
    .rd  (in_rd),
    .rs  (in_rs),
    .res (lg_res)
  );

  always_comb begin
    if (is_shift)      result = sh_res;
    else if (is_arith) result = as_res;
    else               result = lg_res;
  end

  always_comb begin
    nxt_fl.n = result[W-1];
    nxt_fl.z = (result == '0);
    nxt_fl.c = is_shift ? sh_c : (is_arith ? as_c : cur_fl.c);
    nxt_fl.v = is_arith ? as_v : cur_fl.v;
  end

  // Single output register with pass-through ready.
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result <= result;
      out_wr_en  <= wr_en;
      out_flags  <= nxt_fl;
    end
  end

endmodule

// File: rtl/cisa_reg_alu_chk.sv
module cisa_reg_alu_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [W-1:0]     in_rd,
  input logic [AMT_W-1:0] amt,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic             out_wr_en,
  input logic [3:0]       out_flags
);
  logic fire;
  logic op_noreg;
  logic op_keepcv;
  logic op_shift;

  assign fire      = in_valid && in_ready;
  assign op_noreg  = (in_op == 4'd8) || (in_op == 4'd10) || (in_op == 4'd11);
  assign op_keepcv = (in_op == 4'd0) || (in_op == 4'd1) || (in_op == 4'd8) ||
                     (in_op == 4'd12) || (in_op == 4'd13) || (in_op == 4'd14) ||
                     (in_op == 4'd15);
  assign op_shift  = (in_op == 4'd2) || (in_op == 4'd3) || (in_op == 4'd4) ||
                     (in_op == 4'd7);

  // R1
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_flags) && $stable(out_wr_en)));

  // R1
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1
  take_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R3
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_noreg) |=> !out_wr_en);

  // R3
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !op_noreg) |=> out_wr_en);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[2] == (out_result == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3] == out_result[W-1]));

  // R5
  keep_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_keepcv) |=> (out_flags[1:0] == $past(in_flags[1:0])));

  // R9
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_shift && amt == '0) |=>
      (out_result == $past(in_rd) && out_flags[1] == $past(in_flags[1])));

  // R9
  shift_keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_shift) |=> (out_flags[0] == $past(in_flags[0])));

endmodule

bind cisa_reg_alu cisa_reg_alu_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_rd      (in_rd),
  .amt        (in_rs[AMT_W-1:0]),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_flags  (out_flags)
);

// File: tb/test_cisa_reg_alu.sv
`timescale 1ns/1ps
module test_cisa_reg_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_rd = '0;
  logic [31:0] in_rs = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cisa_reg_alu i_cisa_reg_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  // Expected {wr_en, flags[3:0], result[31:0]} from the requirements.
  function automatic logic [36:0] expect_of(input logic [3:0] op, input logic [31:0] d,
                                            input logic [31:0] s, input logic [3:0] f);
    logic [31:0] r;
    logic c, v, wr;
    logic [63:0] full;
    logic [32:0] sum;
    logic [31:0] b;
    int amt;
    int rot;
    amt = int'(s[7:0]);
    c = f[1];
    v = f[0];
    wr = 1'b1;
    r = '0;
    case (op)
      4'd0: r = d & s;
      4'd1: r = d ^ s;
      4'd12: r = d | s;
      4'd14: r = d & ~s;
      4'd15: r = ~s;
      4'd8: begin r = d & s; wr = 1'b0; end
      4'd13: begin full = {32'd0, d} * {32'd0, s}; r = full[31:0]; end
      4'd5, 4'd11, 4'd6, 4'd10, 4'd9: begin
        if (op == 4'd5)       begin sum = {1'b0, d} + {1'b0, s} + {32'd0, f[1]}; b = s; end
        else if (op == 4'd11) begin sum = {1'b0, d} + {1'b0, s}; b = s; wr = 1'b0; end
        else if (op == 4'd6)  begin sum = {1'b0, d} + {1'b0, ~s} + {32'd0, f[1]}; b = ~s; end
        else if (op == 4'd10) begin sum = {1'b0, d} + {1'b0, ~s} + 33'd1; b = ~s; wr = 1'b0; end
        else                  begin sum = {1'b0, ~s} + 33'd1; b = ~s; d = 32'd0; end
        r = sum[31:0];
        c = sum[32];
        v = (d[31] == b[31]) && (r[31] != d[31]);
      end
      4'd2: if (amt != 0) begin
        if (amt > 32) begin r = 0; c = 0; end
        else begin full = {32'd0, d} << amt; r = full[31:0]; c = full[32]; end
      end else r = d;
      4'd3: if (amt != 0) begin
        if (amt > 32) begin r = 0; c = 0; end
        else begin full = {d, 32'd0} >> amt; r = full[63:32]; c = full[31]; end
      end else r = d;
      4'd4: if (amt != 0) begin
        if (amt >= 32) begin r = {32{d[31]}}; c = d[31]; end
        else begin r = 32'($signed(d) >>> amt); c = d[amt-1]; end
      end else r = d;
      default: if (amt != 0) begin
        rot = amt % 32;
        full = {d, d} >> rot;
        r = full[31:0];
        c = r[31];
      end else r = d;
    endcase
    return {wr, r[31], (r == 32'd0), c, v, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [31:0] s);
    case (op)
      4'd0, 4'd1, 4'd12, 4'd14, 4'd15: return "R2";
      4'd8: return "R3";
      4'd13: return "R6";
      4'd5, 4'd11: return "R7";
      4'd6, 4'd9, 4'd10: return "R8";
      default: begin
        if (s[7:0] == 8'd0) return "R9";
        if (op == 4'd4) return "R11";
        if (op == 4'd7) return "R12";
        return "R10";
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                        input logic [3:0] f, input string tag);
    logic [36:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rd = d; in_rs = s; in_flags = f;
    exp = expect_of(op, d, s, f);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {26'd0, out_valid, out_wr_en, out_flags, out_result},
               {26'd0, 1'b1, exp});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [36:0] ea;
    logic [36:0] eb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, out_valid, in_ready}, 64'd1);

    // Directed corner cases
    run_op(4'd0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'b0011, "R4");  // zero result, C/V kept
    run_op(4'd12, 32'h8000_0000, 32'h1, 4'b0000, "R4");
    run_op(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0010, "R2");
    run_op(4'd15, 32'h1234_5678, 32'h0, 4'b0001, "R2");
    run_op(4'd8, 32'h0000_00FF, 32'h0000_0100, 4'b0011, "R3");
    run_op(4'd10, 32'd5, 32'd5, 4'b0000, "R3");
    run_op(4'd11, 32'h7FFF_FFFF, 32'd1, 4'b0000, "R7");
    run_op(4'd5, 32'hFFFF_FFFF, 32'd0, 4'b0010, "R7");
    run_op(4'd6, 32'h8000_0000, 32'd1, 4'b0010, "R8");
    run_op(4'd9, 32'hDEAD_BEEF, 32'h8000_0000, 4'b0000, "R8");
    run_op(4'd9, 32'h0, 32'h0, 4'b0000, "R8");
    run_op(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0011, "R6");
    run_op(4'd2, 32'h0000_0001, 32'd32, 4'b0000, "R10");
    run_op(4'd2, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R10");
    run_op(4'd3, 32'h8000_0000, 32'd32, 4'b0000, "R10");
    run_op(4'd3, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R10");
    run_op(4'd4, 32'h8000_0000, 32'd255, 4'b0000, "R11");
    run_op(4'd4, 32'h8000_0001, 32'd1, 4'b0000, "R11");
    run_op(4'd7, 32'h8000_0001, 32'd64, 4'b0000, "R12");
    run_op(4'd7, 32'h0000_0001, 32'd1, 4'b0000, "R12");
    run_op(4'd4, 32'h8000_0000, 32'd0, 4'b0010, "R9");
    run_op(4'd2, 32'h0000_0003, 32'hFFFF_FF04, 4'b0000, "R13");
    run_op(4'd3, 32'hF000_0000, 32'h0000_0104, 4'b0000, "R13");

    // R1: back-pressure
    ea = expect_of(4'd5, 32'd100, 32'd23, 4'b0010);
    eb = expect_of(4'd1, 32'hAAAA_0000, 32'h5555_FFFF, 4'b0000);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'd5; in_rd = 32'd100; in_rs = 32'd23; in_flags = 4'b0010;
    @(negedge clk);
    check("R1", {26'd0, out_valid, ea}, {26'd0, 1'b1, ea});
    check("R1", {63'd0, in_ready}, 64'd0);
    in_op = 4'd1; in_rd = 32'hAAAA_0000; in_rs = 32'h5555_FFFF; in_flags = 4'b0000;
    repeat (2) @(negedge clk);
    check("R1", {26'd0, out_valid, out_wr_en, out_flags, out_result}, {26'd0, 1'b1, ea});
    out_ready = 1'b1;
    @(negedge clk);
    check("R1", {26'd0, out_valid, out_wr_en, out_flags, out_result}, {26'd0, 1'b1, eb});
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);

    // Random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op;
      logic [31:0] d;
      logic [31:0] s;
      logic [3:0]  f;
      int pick;
      op = 4'($urandom_range(0, 15));
      d  = $urandom();
      s  = $urandom();
      f  = 4'($urandom_range(0, 15));
      pick = $urandom_range(0, 3);
      if (pick == 0) s[7:0] = 8'($urandom_range(0, 40));
      else if (pick == 1) s[7:0] = 8'($urandom_range(28, 36));
      else if (pick == 2 && $urandom_range(0, 1) == 1) s[7:0] = 8'd255;
      if ($urandom_range(0, 7) == 0) d = 32'h8000_0000;
      run_op(op, d, s, f, tag_of(op, s));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule